// File: doc/BRIEF.md
# Software-Managed Translation Buffer Register File

This block holds a small, fully associative set of translation entries together with the register file a CPU uses to maintain them. Software loads an entry-high word (page-pair tag and address-space ID), two entry-low words (one for the even page and one for the odd page of a pair), a page-size mask, a memory-map ID and an index. It then issues one of five commands. Write-indexed copies the registers into the entry chosen by the index. Read copies that entry back into the registers. Probe searches every entry in parallel and reports where it matched. Space-invalidate and flush mark entries as invalid.

The number of usable entries is one plus a configuration field, and can be anything from 1 up to the built capacity. Each entry carries a hardware invalid flag that is separate from its per-page valid bits. A mode input picks how address spaces are told apart: by the 8-bit ASID held in entry-high, or by the separate 16-bit memory-map ID. Every command completes in one clock cycle and raises a one-cycle done pulse.

Top module: `tlb_regif`

## Requirements
- R1: When `reg_we_i` is high and `cmd_valid_i` is low, `reg_wdata_i` is loaded into the register chosen by `reg_sel_i`: 0 = entry-high, 1 = entry-low even, 2 = entry-low odd, 3 = page mask, 4 = memory-map ID (low 16 bits), 5 = index. The register shows on its output after the next edge.
- R2: A command accepted on one edge updates the entries and registers on that same edge, and raises `done_o` for exactly the following cycle. Command codes: 1 write-indexed, 2 read, 3 probe, 4 space-invalidate, 5 flush.
- R3: The entry count is `cfg_size_i` + 1. Write-indexed and read use index bits 30:0 (bit 31 ignored) modulo that count.
- R4: Write-indexed stores the following. Tag = entry-high & 0xFFFFE000. ASID = entry-high[7:0]. Invalid flag = entry-high[10]. Page mask = mask register & 0x1FFFE000. Global = AND of bit 0 of both entry-low words. From each entry-low word it stores valid [1], dirty [2], cache attribute [5:3], frame number [25:6], execute-inhibit [30] and read-inhibit [31].
- R5: Reading a valid entry rebuilds both entry-low words in the R4 layout, with the global bit in bit 0 of each and all other bits zero. It also returns the page mask and memory-map ID. Entry-high is tag | ASID in ASID mode and the tag alone in memory-map-ID mode.
- R6: Reading an entry whose invalid flag is set writes entry-high = 0x00000400 and zeros both entry-low words and the page mask.
- R7: An entry within the count matches a probe when its invalid flag is clear and its tag equals entry-high, both compared only above bit (mask | 0x1FFF). It must also be global or have a matching space ID.
- R8: A probe hit writes the lowest matching entry number into the index with bit 31 clear. A miss writes 0x80000000.
- R9: With `mmid_mode_i` high, the space ID is the memory-map ID register compared against the stored memory-map ID. Otherwise it is entry-high[7:0] compared against the stored ASID.
- R10: Space-invalidate sets the invalid flag of every non-global entry whose space ID matches the current one. Global entries and entries of other spaces keep matching.
- R11: Flush sets the invalid flag of every entry.
- R12: After reset every register reads zero, `done_o` is low, and every entry is invalid, so any probe misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_size_i | input | 6 | Entry count minus one |
| mmid_mode_i | input | 1 | 1 = memory-map-ID tagging, 0 = ASID tagging |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select (R1 encoding) |
| reg_wdata_i | input | 32 | Register write data |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code (R2 encoding) |
| done_o | output | 1 | One-cycle completion pulse |
| entry_hi_o | output | 32 | Entry-high register |
| entry_lo0_o | output | 32 | Entry-low register, even page |
| entry_lo1_o | output | 32 | Entry-low register, odd page |
| page_mask_o | output | 32 | Page mask register |
| mmid_o | output | 16 | Memory-map ID register |
| index_o | output | 32 | Index register |

## Verification
The assertions assume that `cfg_size_i` and `mmid_mode_i` change only between commands. They also assume that a register write never coincides with a command, because a coincident write is dropped and the entry-high write check is gated on exactly that. The stimulus changes inputs only at the falling edge and holds each strobe for a single cycle. It issues register writes and commands in separate cycles and changes the mode and size inputs only while the block is idle, so every checked window starts from a settled state.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int ASID_W    = 8;
  localparam int MMID_W    = 16;
  localparam int PFN_W     = 20;
  localparam int PFN_LSB   = 6;
  localparam int XI_BIT    = 30;
  localparam int RI_BIT    = 31;
  localparam int INV_BIT   = 10;
  localparam int DPAGE_LSB = 13;

  localparam logic [31:0] TAG_MASK    = ~((32'h1 << DPAGE_LSB) - 32'h1);
  localparam logic [31:0] PMASK_FIELD = 32'h1FFF_E000;

  typedef struct packed {
    logic             ri;
    logic             xi;
    logic             v;
    logic             d;
    logic [2:0]       c;
    logic [PFN_W-1:0] pfn;
  } page_attr_t;

  typedef struct packed {
    logic              inv;
    logic              g;
    logic [31:0]       tag;
    logic [31:0]       pmask;
    logic [ASID_W-1:0] asid;
    logic [MMID_W-1:0] mmid;
    page_attr_t [1:0]  page;
  } tlb_entry_t;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_WRITE = 3'd1,
    CMD_READ  = 3'd2,
    CMD_PROBE = 3'd3,
    CMD_INV   = 3'd4,
    CMD_FLUSH = 3'd5
  } tlb_cmd_e;

  typedef enum logic [2:0] {
    SEL_HI    = 3'd0,
    SEL_LO0   = 3'd1,
    SEL_LO1   = 3'd2,
    SEL_PMASK = 3'd3,
    SEL_MMID  = 3'd4,
    SEL_INDEX = 3'd5
  } reg_sel_e;

  function automatic page_attr_t lo_unpack(input logic [31:0] lo);
    page_attr_t p;
    p.v   = lo[1];
    p.d   = lo[2];
    p.c   = lo[5:3];
    p.pfn = lo[PFN_LSB +: PFN_W];
    p.xi  = lo[XI_BIT];
    p.ri  = lo[RI_BIT];
    return p;
  endfunction

  function automatic logic [31:0] lo_pack(input page_attr_t p, input logic g);
    logic [31:0] lo;
    lo                     = '0;
    lo[0]                  = g;
    lo[1]                  = p.v;
    lo[2]                  = p.d;
    lo[5:3]                = p.c;
    lo[PFN_LSB +: PFN_W]   = p.pfn;
    lo[XI_BIT]             = p.xi;
    lo[RI_BIT]             = p.ri;
    return lo;
  endfunction

  function automatic logic [MMID_W-1:0] entry_space(input tlb_entry_t e, input logic mm);
    return mm ? e.mmid : MMID_W'(e.asid);
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int N     = 64,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  tlb_entry_t        wr_entry_i,
  input  logic              inv_en_i,
  input  logic [MMID_W-1:0] space_i,
  input  logic              mmid_mode_i,
  input  logic              flush_i,
  output tlb_entry_t        entries_o [N]
);
  tlb_entry_t entries_q [N];

  for (genvar g = 0; g < N; g++) begin : gen_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        entries_q[g]     <= '0;
        entries_q[g].inv <= 1'b1;
      end else if (flush_i) begin
        entries_q[g].inv <= 1'b1;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        entries_q[g] <= wr_entry_i;
      end else if (inv_en_i && !entries_q[g].g &&
                   entry_space(entries_q[g], mmid_mode_i) == space_i) begin
        entries_q[g].inv <= 1'b1;
      end
    end
    assign entries_o[g] = entries_q[g];
  end
endmodule

// File: rtl/tlb_cam_match.sv
module tlb_cam_match
  import tlb_pkg::*;
#(
  parameter int N     = 64,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1,
  parameter int CNT_W = $clog2(N + 1)
) (
  input  logic              inv_i   [N],
  input  logic              g_i     [N],
  input  logic [31:0]       tag_i   [N],
  input  logic [31:0]       pmask_i [N],
  input  logic [MMID_W-1:0] space_i [N],
  input  logic [CNT_W-1:0]  count_i,
  input  logic [31:0]       req_tag_i,
  input  logic [MMID_W-1:0] req_space_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o
);
  logic [N-1:0] match_vec;

  for (genvar g = 0; g < N; g++) begin : gen_cmp
    logic [31:0] keep;
    assign keep = ~(pmask_i[g] | ~TAG_MASK);
    assign match_vec[g] = (CNT_W'(g) < count_i) && !inv_i[g] &&
                          ((tag_i[g] & keep) == (req_tag_i & keep)) &&
                          (g_i[g] || space_i[g] == req_space_i);
  end

  // lowest index wins
  always_comb begin
    hit_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |match_vec;
endmodule

// File: rtl/tlb_regif.sv
module tlb_regif
  import tlb_pkg::*;
#(
  parameter int N_MAX = 64,
  parameter int CFG_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CFG_W-1:0]  cfg_size_i,
  input  logic              mmid_mode_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  output logic              done_o,
  output logic [31:0]       entry_hi_o,
  output logic [31:0]       entry_lo0_o,
  output logic [31:0]       entry_lo1_o,
  output logic [31:0]       page_mask_o,
  output logic [MMID_W-1:0] mmid_o,
  output logic [31:0]       index_o
);
  localparam int IDX_W = (N_MAX > 1) ? $clog2(N_MAX) : 1;
  localparam int CNT_W = $clog2(N_MAX + 1);

  logic [31:0]       hi_q, lo0_q, lo1_q, pmask_q, index_q;
  logic [MMID_W-1:0] mmid_q;
  logic              done_q;

  logic [CNT_W-1:0]  entry_count;
  logic [IDX_W-1:0]  sel_idx;
  logic [MMID_W-1:0] cur_space;
  tlb_entry_t        wr_entry;
  tlb_entry_t        rd_entry;
  tlb_entry_t        entries [N_MAX];
  logic              probe_hit;
  logic [IDX_W-1:0]  probe_idx;

  logic              cam_inv   [N_MAX];
  logic              cam_g     [N_MAX];
  logic [31:0]       cam_tag   [N_MAX];
  logic [31:0]       cam_pmask [N_MAX];
  logic [MMID_W-1:0] cam_space [N_MAX];

  logic do_write, do_read, do_probe, do_inv, do_flush;

  assign do_write = cmd_valid_i && cmd_op_i == CMD_WRITE;
  assign do_read  = cmd_valid_i && cmd_op_i == CMD_READ;
  assign do_probe = cmd_valid_i && cmd_op_i == CMD_PROBE;
  assign do_inv   = cmd_valid_i && cmd_op_i == CMD_INV;
  assign do_flush = cmd_valid_i && cmd_op_i == CMD_FLUSH;

  assign entry_count = CNT_W'(cfg_size_i) + CNT_W'(1);
  assign sel_idx     = IDX_W'(index_q[30:0] % 31'(entry_count));
  assign cur_space   = mmid_mode_i ? mmid_q : MMID_W'(hi_q[ASID_W-1:0]);

  always_comb begin
    wr_entry         = '0;
    wr_entry.inv     = hi_q[INV_BIT];
    wr_entry.g       = lo0_q[0] & lo1_q[0];
    wr_entry.tag     = hi_q & TAG_MASK;
    wr_entry.pmask   = pmask_q & PMASK_FIELD;
    wr_entry.asid    = hi_q[ASID_W-1:0];
    wr_entry.mmid    = mmid_q;
    wr_entry.page[0] = lo_unpack(lo0_q);
    wr_entry.page[1] = lo_unpack(lo1_q);
  end

  tlb_entry_store #(.N(N_MAX), .IDX_W(IDX_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (do_write),
    .wr_idx_i   (sel_idx),
    .wr_entry_i (wr_entry),
    .inv_en_i   (do_inv),
    .space_i    (cur_space),
    .mmid_mode_i(mmid_mode_i),
    .flush_i    (do_flush),
    .entries_o  (entries)
  );

  for (genvar g = 0; g < N_MAX; g++) begin : gen_cam_in
    assign cam_inv[g]   = entries[g].inv;
    assign cam_g[g]     = entries[g].g;
    assign cam_tag[g]   = entries[g].tag;
    assign cam_pmask[g] = entries[g].pmask;
    assign cam_space[g] = entry_space(entries[g], mmid_mode_i);
  end

  tlb_cam_match #(.N(N_MAX), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_match (
    .inv_i      (cam_inv),
    .g_i        (cam_g),
    .tag_i      (cam_tag),
    .pmask_i    (cam_pmask),
    .space_i    (cam_space),
    .count_i    (entry_count),
    .req_tag_i  (hi_q),
    .req_space_i(cur_space),
    .hit_o      (probe_hit),
    .hit_idx_o  (probe_idx)
  );

  assign rd_entry = entries[sel_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      lo0_q   <= '0;
      lo1_q   <= '0;
      pmask_q <= '0;
      mmid_q  <= '0;
      index_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= cmd_valid_i;
      if (do_read) begin
        if (rd_entry.inv) begin
          hi_q    <= 32'h1 << INV_BIT;
          lo0_q   <= '0;
          lo1_q   <= '0;
          pmask_q <= '0;
        end else begin
          hi_q    <= mmid_mode_i ? rd_entry.tag
                                 : (rd_entry.tag | 32'(rd_entry.asid));
          lo0_q   <= lo_pack(rd_entry.page[0], rd_entry.g);
          lo1_q   <= lo_pack(rd_entry.page[1], rd_entry.g);
          pmask_q <= rd_entry.pmask;
          mmid_q  <= rd_entry.mmid;
        end
      end else if (do_probe) begin
        index_q <= probe_hit ? 32'(probe_idx) : 32'h8000_0000;
      end else if (reg_we_i && !cmd_valid_i) begin
        case (reg_sel_i)
          SEL_HI:    hi_q    <= reg_wdata_i;
          SEL_LO0:   lo0_q   <= reg_wdata_i;
          SEL_LO1:   lo1_q   <= reg_wdata_i;
          SEL_PMASK: pmask_q <= reg_wdata_i;
          SEL_MMID:  mmid_q  <= reg_wdata_i[MMID_W-1:0];
          SEL_INDEX: index_q <= reg_wdata_i;
          default:   ;
        endcase
      end
    end
  end

  assign done_o      = done_q;
  assign entry_hi_o  = hi_q;
  assign entry_lo0_o = lo0_q;
  assign entry_lo1_o = lo1_q;
  assign page_mask_o = pmask_q;
  assign mmid_o      = mmid_q;
  assign index_o     = index_q;
endmodule

// File: rtl/tlb_regif_chk.sv
module tlb_regif_chk
  import tlb_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [2:0]       cmd_op_i,
  input logic             reg_we_i,
  input logic [2:0]       reg_sel_i,
  input logic [31:0]      reg_wdata_i,
  input logic             done_o,
  input logic [31:0]      entry_hi_o,
  input logic [31:0]      entry_lo0_o,
  input logic [31:0]      entry_lo1_o,
  input logic [31:0]      index_o,
  input logic             probe_hit_i,
  input logic [CNT_W-1:0] count_i
);
  assert_done_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> done_o);

  assert_done_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !done_o);

  assert_hi_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !cmd_valid_i && reg_sel_i == SEL_HI) |=> entry_hi_o == $past(reg_wdata_i));

  assert_probe_miss_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == CMD_PROBE && !probe_hit_i) |=> index_o == 32'h8000_0000);

  assert_probe_hit_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == CMD_PROBE && probe_hit_i) |=>
      (!index_o[31] && index_o < 32'($past(count_i))));

  assert_flush_empties_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == CMD_FLUSH) |=> !probe_hit_i);

  assert_read_global_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == CMD_READ) |=> entry_lo0_o[0] == entry_lo1_o[0]);

  assert_read_invalid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == CMD_READ) |=>
      (!entry_hi_o[INV_BIT] || (entry_lo0_o == 32'h0 && entry_lo1_o == 32'h0)));
endmodule

bind tlb_regif tlb_regif_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .done_o      (done_o),
  .entry_hi_o  (entry_hi_o),
  .entry_lo0_o (entry_lo0_o),
  .entry_lo1_o (entry_lo1_o),
  .index_o     (index_o),
  .probe_hit_i (probe_hit),
  .count_i     (entry_count)
);

// File: tb/tlb_regif_tb.sv
`timescale 1ns/1ps
module tlb_regif_tb;
  import tlb_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cfg_size = 6'd7;
  logic        mm = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic        cmd_v = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic        done;
  logic [31:0] hi, lo0, lo1, pm, idx;
  logic [15:0] mmid;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  tlb_regif u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_size_i(cfg_size), .mmid_mode_i(mm),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .cmd_valid_i(cmd_v), .cmd_op_i(cmd_op), .done_o(done),
    .entry_hi_o(hi), .entry_lo0_o(lo0), .entry_lo1_o(lo1),
    .page_mask_o(pm), .mmid_o(mmid), .index_o(idx)
  );

  // idx, hi, lo0, lo1, mask
  localparam int NV = 5;
  localparam logic [159:0] VEC [NV] = '{
    {32'd0, 32'h0001_2034, 32'h0000_1047, 32'h4000_2042, 32'h0000_0000},
    {32'd1, 32'h8000_40FF, 32'h8000_001B, 32'h0000_0381, 32'h0000_6000},
    {32'd3, 32'h7FFF_E001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1FFF_E000},
    {32'd5, 32'h0000_0000, 32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF},
    {32'd7, 32'h1234_4234, 32'h0000_0003, 32'h0000_0001, 32'h0000_0000}
  };

  function automatic logic [31:0] exp_hi(input logic [31:0] h, input logic m);
    return m ? (h & 32'hFFFF_E000) : ((h & 32'hFFFF_E000) | (h & 32'h0000_00FF));
  endfunction

  function automatic logic [31:0] exp_lo(input logic [31:0] l, input logic g);
    return (l & 32'hC3FF_FFFE) | {31'd0, g};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run_cmd(input logic [2:0] op);
    @(negedge clk);
    cmd_v = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_v = 1'b0;
    chk("R2 done pulse", {31'd0, done}, 32'd1);
  endtask

  task automatic write_entry(input logic [31:0] i, input logic [31:0] h,
                             input logic [31:0] l0, input logic [31:0] l1,
                             input logic [31:0] m);
    wr_reg(SEL_HI, h);
    wr_reg(SEL_LO0, l0);
    wr_reg(SEL_LO1, l1);
    wr_reg(SEL_PMASK, m);
    wr_reg(SEL_INDEX, i);
    run_cmd(CMD_WRITE);
  endtask

  task automatic read_entry(input logic [31:0] i);
    wr_reg(SEL_INDEX, i);
    run_cmd(CMD_READ);
  endtask

  task automatic probe(input logic [31:0] h, input logic [31:0] exp, input string req);
    wr_reg(SEL_HI, h);
    run_cmd(CMD_PROBE);
    chk(req, idx, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 hi after reset", hi, 32'h0);
    chk("R12 lo0 after reset", lo0, 32'h0);
    chk("R12 index after reset", idx, 32'h0);
    chk("R12 done low after reset", {31'd0, done}, 32'h0);
    probe(32'h0, 32'h8000_0000, "R12 probe misses after reset");
    @(negedge clk);
    chk("R2 done single cycle", {31'd0, done}, 32'h0);

    // R1 register writes
    wr_reg(SEL_MMID, 32'h1234_ABCD);
    chk("R1 mmid write", {16'd0, mmid}, 32'h0000_ABCD);
    wr_reg(SEL_INDEX, 32'h8000_0003);
    chk("R1 index write", idx, 32'h8000_0003);
    wr_reg(SEL_LO1, 32'h5A5A_0F0F);
    chk("R1 lo1 write", lo1, 32'h5A5A_0F0F);
    wr_reg(SEL_MMID, 32'h0);

    // R4/R5 table: write all, then read back
    for (int v = 0; v < NV; v++) begin
      write_entry(VEC[v][159:128], VEC[v][127:96], VEC[v][95:64], VEC[v][63:32], VEC[v][31:0]);
    end
    for (int v = 0; v < NV; v++) begin
      logic g;
      g = VEC[v][64] & VEC[v][32];
      wr_reg(SEL_HI, 32'hDEAD_0000);
      read_entry(VEC[v][159:128]);
      chk("R4 R5 read hi", hi, exp_hi(VEC[v][127:96], 1'b0));
      chk("R4 R5 read lo0", lo0, exp_lo(VEC[v][95:64], g));
      chk("R4 R5 read lo1", lo1, exp_lo(VEC[v][63:32], g));
      chk("R4 R5 read mask", pm, VEC[v][31:0] & 32'h1FFF_E000);
    end

    // R7 R9 probes
    probe(32'h0001_2034, 32'd0, "R7 exact tag and asid hit");
    probe(32'h0001_2035, 32'h8000_0000, "R9 asid mismatch misses");
    probe(32'h8000_7011, 32'd1, "R7 page mask widens compare on global entry");
    probe(32'h8001_0011, 32'h8000_0000, "R7 outside page mask misses");

    // R8 lowest index wins; R3 modulo
    write_entry(32'd6, 32'h0001_2034, 32'h2, 32'h2, 32'h0);
    probe(32'h0001_2034, 32'd0, "R8 lowest of two matches");
    write_entry(32'd10, 32'h0AAA_0034, 32'h6, 32'h2, 32'h0);
    read_entry(32'd2);
    chk("R3 index 10 mod 8 lands on entry 2", hi, 32'h0AAA_0034);
    chk("R3 modulo entry lo0", lo0, 32'h6);
    probe(32'h0AAA_0034, 32'd2, "R8 hit writes index");

    // R10 space invalidate
    wr_reg(SEL_HI, 32'h0000_0034);
    run_cmd(CMD_INV);
    probe(32'h0001_2034, 32'h8000_0000, "R10 non-global same space invalidated");
    probe(32'h0AAA_0034, 32'h8000_0000, "R10 modulo entry invalidated");
    probe(32'h1234_4034, 32'd7, "R10 global entry survives");
    probe(32'h0000_0000, 32'd5, "R10 other space survives");
    probe(32'h8000_7011, 32'd1, "R10 other space global survives");

    // R6 invalid read
    read_entry(32'd0);
    chk("R6 invalid read hi", hi, 32'h0000_0400);
    chk("R6 invalid read lo0", lo0, 32'h0);
    chk("R6 invalid read lo1", lo1, 32'h0);
    chk("R6 invalid read mask", pm, 32'h0);

    // R9 memory-map-ID mode
    @(negedge clk); mm = 1'b1;
    wr_reg(SEL_MMID, 32'h0000_0ABC);
    write_entry(32'd4, 32'h0055_0012, 32'h2, 32'h2, 32'h0);
    probe(32'h0055_0077, 32'd4, "R9 mmid match ignores asid");
    wr_reg(SEL_MMID, 32'h0000_0ABD);
    probe(32'h0055_0012, 32'h8000_0000, "R9 mmid mismatch misses");
    read_entry(32'd4);
    chk("R5 mmid-mode read hi drops asid", hi, 32'h0055_0000);
    chk("R5 read restores mmid", {16'd0, mmid}, 32'h0000_0ABC);
    @(negedge clk); mm = 1'b0;
    read_entry(32'd4);
    chk("R5 asid-mode read hi", hi, 32'h0055_0012);

    // R11 flush
    run_cmd(CMD_FLUSH);
    probe(32'h1234_4034, 32'h8000_0000, "R11 global entry flushed");
    probe(32'h8000_7011, 32'h8000_0000, "R11 entry 1 flushed");
    probe(32'h0000_0000, 32'h8000_0000, "R11 entry 5 flushed");

    // R3 full size, bit 31 ignored
    @(negedge clk); cfg_size = 6'd63;
    write_entry(32'd70, 32'h0BBB_2000, 32'h0, 32'h0, 32'h0);
    read_entry(32'd6);
    chk("R3 index 70 mod 64 lands on entry 6", hi, 32'h0BBB_2000);
    probe(32'h0BBB_2000, 32'd6, "R3 probe finds entry 6");
    write_entry(32'h8000_0009, 32'h0CCC_0000, 32'h0, 32'h0, 32'h0);
    probe(32'h0CCC_0000, 32'd9, "R3 index bit 31 ignored");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule